// File: doc/BRIEF.md
# Flag-Setting Arithmetic and Logic Unit

This block is a datapath unit of configurable width. It combines two operands with one of nine operations: add, subtract, AND, OR, exclusive-OR, bit-clear, inverted move, logical left shift and logical right shift. The result is combinational from the inputs. Beside the result the unit holds a four-bit condition register with the fields N (negative), Z (zero), C (carry) and V (signed overflow). That register is written on a rising clock edge only when the set-flags input is high, so a sequence of operations can leave the conditions from an earlier operation in place for later tests.

The shift operations move operand A by an immediate amount. The carry field records the last bit pushed out. Subtraction reports carry in the "no borrow" sense. Logical operations update N and Z and leave C and V as they were. Reset is asserted asynchronously and released through a two-stage synchronizer, so the condition register stays at 0000 for the first two rising edges after the reset input rises.

Top module: `flag_alu`

## Requirements
- R1: Opcode 0 (add) gives A+B modulo 2^WIDTH. With set-flags high, C takes the unsigned carry out of the top bit, and V is set when A and B have the same sign and the result's sign differs from it.
- R2: Opcode 1 (subtract) gives A-B modulo 2^WIDTH. With set-flags high, C is 1 when A >= B unsigned (no borrow) and 0 otherwise. V is set when A and B differ in sign and the result's sign differs from A. Subtracting a value from itself gives flags 0110.
- R3: Opcodes 2, 3, 4, 5 and 6 give A AND B, A OR B, A XOR B, A AND NOT B, and NOT B respectively.
- R4: For every opcode 0 to 8 with set-flags high, N (flags bit 3) takes the result's top bit and Z (flags bit 2) is 1 exactly when the result is zero.
- R5: A flag-setting operation with opcodes 2 to 6 leaves C (flags bit 1) and V (flags bit 0) at their previous values.
- R6: Opcode 7 gives A shifted left by the shift amount, and opcode 8 gives A shifted right with zero fill. With set-flags high and a non-zero amount, C takes the last bit shifted out of A, and V is kept.
- R7: A shift by zero returns A unchanged and, when flag-setting, keeps C.
- R8: With set-flags low, the flag register keeps its value whatever the operation and result.
- R9: Opcodes 9 to 15 are reserved. They give a zero result and leave all four flags unchanged even with set-flags high.
- R10: While rst_n is low the flags read 0000 without waiting for a clock edge. After rst_n rises, the first two rising edges do not update the flags, and the third one does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | WIDTH | Operand A, also the shifted value |
| op_b | input | WIDTH | Operand B |
| opcode | input | 4 | Operation select (0..8 defined, 9..15 reserved) |
| shamt | input | $clog2(WIDTH) | Immediate shift amount |
| set_flags | input | 1 | Write the condition register at the next rising edge |
| result | output | WIDTH | Combinational operation result |
| flags | output | 4 | Condition register {N, Z, C, V} |

## Verification
The hardest case to reach is a state where C and V hold values that a logical or zero-length shift must preserve. A flag register that only ever holds values left by the previous arithmetic step cannot tell "keep" from "clear". The stimulus therefore first makes a subtraction that leaves both C and V set. It then issues AND, BIC and zero-amount shifts with set-flags high and checks that those two bits survive. The reset window is reached by presenting a flag-setting subtraction at the same moment rst_n rises and watching that the flags change only on the third edge.

// File: rtl/flag_alu_pkg.sv
`timescale 1ns/1ps
package flag_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_AND = 4'd2,
    OP_ORR = 4'd3,
    OP_EOR = 4'd4,
    OP_BIC = 4'd5,
    OP_MVN = 4'd6,
    OP_LSL = 4'd7,
    OP_LSR = 4'd8
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  localparam nzcv_t NZCV_CLEAR = '{n: 1'b0, z: 1'b0, c: 1'b0, v: 1'b0};

endpackage

// File: rtl/alu_rst_sync.sv
`timescale 1ns/1ps
module alu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '0;
    end else begin
      pipe_q <= pipe_d;
    end
  end

  assign rst_sync_n = pipe_q[STAGES-1];

endmodule

// File: rtl/alu_addsub.sv
`timescale 1ns/1ps
module alu_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             sub,
  output logic [WIDTH-1:0] sum,
  output logic             carry,
  output logic             ovf
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   wide;

  always_comb begin
    b_eff = sub ? ~b : b;
    wide  = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub};
    sum   = wide[MSB:0];
    carry = wide[WIDTH];
    ovf   = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
  end

endmodule

// File: rtl/alu_bitwise.sv
`timescale 1ns/1ps
module alu_bitwise
  import flag_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [3:0]       sel,
  output logic [WIDTH-1:0] y
);

  always_comb begin
    case (sel)
      OP_AND:  y = a & b;
      OP_ORR:  y = a | b;
      OP_EOR:  y = a ^ b;
      OP_BIC:  y = a & ~b;
      OP_MVN:  y = ~b;
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/alu_shifter.sv
`timescale 1ns/1ps
module alu_shifter #(
  parameter int WIDTH = 32,
  localparam int SHW = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] a,
  input  logic [SHW-1:0]   amt,
  input  logic             left,
  output logic [WIDTH-1:0] y,
  output logic             cout,
  output logic             active
);

  logic [WIDTH:0] ext_l;
  logic [WIDTH:0] ext_r;

  always_comb begin
    ext_l  = {1'b0, a} << amt;
    ext_r  = {a, 1'b0} >> amt;
    active = (amt != '0);
    if (left) begin
      y    = ext_l[WIDTH-1:0];
      cout = ext_l[WIDTH];
    end else begin
      y    = ext_r[WIDTH:1];
      cout = ext_r[0];
    end
  end

endmodule

// File: rtl/alu_flag_reg.sv
`timescale 1ns/1ps
module alu_flag_reg
  import flag_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] res,
  input  logic             c_upd,
  input  logic             c_new,
  input  logic             v_upd,
  input  logic             v_new,
  output nzcv_t            flags_q
);

  nzcv_t flags_d;

  always_comb begin
    flags_d   = flags_q;
    flags_d.n = res[WIDTH-1];
    flags_d.z = (res == '0);
    if (c_upd) flags_d.c = c_new;
    if (v_upd) flags_d.v = v_new;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= NZCV_CLEAR;
    end else if (wr_en) begin
      flags_q <= flags_d;
    end
  end

endmodule

// File: rtl/flag_alu.sv
`timescale 1ns/1ps
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int SHW = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [3:0]       opcode,
  input  logic [SHW-1:0]   shamt,
  input  logic             set_flags,
  output logic [WIDTH-1:0] result,
  output logic [3:0]       flags
);

  logic             rst_sync_n;
  logic [WIDTH-1:0] as_sum;
  logic             as_carry;
  logic             as_ovf;
  logic [WIDTH-1:0] bw_y;
  logic [WIDTH-1:0] sh_y;
  logic             sh_cout;
  logic             sh_active;
  logic             is_arith;
  logic             is_logic;
  logic             is_shift;
  logic             op_valid;
  logic             c_upd;
  logic             c_new;
  logic             v_upd;
  logic             wr_en;
  nzcv_t            flags_q;

  alu_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a     (op_a),
    .b     (op_b),
    .sub   (opcode == OP_SUB),
    .sum   (as_sum),
    .carry (as_carry),
    .ovf   (as_ovf)
  );

  alu_bitwise #(.WIDTH(WIDTH)) u_bitwise (
    .a   (op_a),
    .b   (op_b),
    .sel (opcode),
    .y   (bw_y)
  );

  alu_shifter #(.WIDTH(WIDTH)) u_shifter (
    .a      (op_a),
    .amt    (shamt),
    .left   (opcode == OP_LSL),
    .y      (sh_y),
    .cout   (sh_cout),
    .active (sh_active)
  );

  // operation class decode and result select
  always_comb begin
    is_arith = (opcode == OP_ADD) || (opcode == OP_SUB);
    is_shift = (opcode == OP_LSL) || (opcode == OP_LSR);
    is_logic = (opcode >= OP_AND) && (opcode <= OP_MVN);
    op_valid = is_arith || is_shift || is_logic;
    if (is_arith)      result = as_sum;
    else if (is_shift) result = sh_y;
    else if (is_logic) result = bw_y;
    else               result = '0;
  end

  // which condition fields the current operation may write
  always_comb begin
    c_upd = is_arith || (is_shift && sh_active);
    c_new = is_arith ? as_carry : sh_cout;
    v_upd = is_arith;
    wr_en = set_flags && op_valid;
  end

  alu_flag_reg #(.WIDTH(WIDTH)) u_flag_reg (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .res     (result),
    .c_upd   (c_upd),
    .c_new   (c_new),
    .v_upd   (v_upd),
    .v_new   (as_ovf),
    .flags_q (flags_q)
  );

  assign flags = flags_q;

endmodule

// File: rtl/flag_alu_chk.sv
`timescale 1ns/1ps
module flag_alu_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             run,
  input logic             set_flags,
  input logic [3:0]       opcode,
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic [WIDTH-1:0] result,
  input logic [3:0]       flags
);

  p_reset_clear_r10: assert property (@(posedge clk)
    !run |-> flags == 4'b0000);

  p_hold_r8: assert property (@(posedge clk) disable iff (!run)
    (!set_flags || opcode > 4'd8) |=> $stable(flags));

  p_zero_flag_r4: assert property (@(posedge clk) disable iff (!run)
    (set_flags && opcode <= 4'd8) |=> flags[2] == ($past(result) == '0));

  p_neg_flag_r4: assert property (@(posedge clk) disable iff (!run)
    (set_flags && opcode <= 4'd8) |=> flags[3] == $past(result[WIDTH-1]));

  p_keep_cv_r5: assert property (@(posedge clk) disable iff (!run)
    (set_flags && opcode >= 4'd2 && opcode <= 4'd6) |=> flags[1:0] == $past(flags[1:0]));

  p_sub_self_r2: assert property (@(posedge clk) disable iff (!run)
    (set_flags && opcode == 4'd1 && op_a == op_b) |=> flags == 4'b0110);

endmodule

bind flag_alu flag_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .run       (rst_sync_n),
  .set_flags (set_flags),
  .opcode    (opcode),
  .op_a      (op_a),
  .op_b      (op_b),
  .result    (result),
  .flags     (flags)
);

// File: tb/flag_alu_bench.sv
`timescale 1ns/1ps
module flag_alu_bench;

  localparam int W   = 32;
  localparam int SHW = $clog2(W);

  logic         clk;
  logic         rst_n;
  logic [W-1:0] op_a;
  logic [W-1:0] op_b;
  logic [3:0]   opcode;
  logic [SHW-1:0] shamt;
  logic         set_flags;
  logic [W-1:0] result;
  logic [3:0]   flags;

  int checks;
  int fails;
  bit done;
  logic [3:0] exp_flags;

  logic [W-1:0] q_res[$];
  logic [3:0]   q_flg[$];
  string        q_tag[$];

  flag_alu #(.WIDTH(W)) u_flag_alu (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_a      (op_a),
    .op_b      (op_b),
    .opcode    (opcode),
    .shamt     (shamt),
    .set_flags (set_flags),
    .result    (result),
    .flags     (flags)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // expected-value model derived from the requirements: returns {flags, result}
  function automatic logic [W+3:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                         input logic [3:0] op, input logic [SHW-1:0] sh,
                                         input logic sf, input logic [3:0] f);
    logic [W-1:0] r;
    logic [W:0]   t;
    logic n, z, c, v, ok;
    c = f[1]; v = f[0]; ok = 1'b1; r = '0;
    case (op)
      4'd0: begin t = {1'b0, a} + {1'b0, b}; r = t[W-1:0]; c = t[W];
                  v = (a[W-1] == b[W-1]) && (r[W-1] != a[W-1]); end
      4'd1: begin r = a - b; c = (a >= b);
                  v = (a[W-1] != b[W-1]) && (r[W-1] != a[W-1]); end
      4'd2: r = a & b;
      4'd3: r = a | b;
      4'd4: r = a ^ b;
      4'd5: r = a & ~b;
      4'd6: r = ~b;
      4'd7: begin r = a << sh; if (sh != 0) c = a[W-int'(sh)]; end
      4'd8: begin r = a >> sh; if (sh != 0) c = a[int'(sh)-1]; end
      default: ok = 1'b0;
    endcase
    n = r[W-1]; z = (r == '0);
    if (sf && ok) return {n, z, c, v, r};
    return {f, r};
  endfunction

  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b, input logic [3:0] op,
                       input logic [SHW-1:0] sh, input logic sf, input string tag);
    logic [W+3:0] m;
    @(negedge clk);
    op_a = a; op_b = b; opcode = op; shamt = sh; set_flags = sf;
    m = model(a, b, op, sh, sf, exp_flags);
    exp_flags = m[W+3:W];
    q_res.push_back(m[W-1:0]);
    q_flg.push_back(m[W+3:W]);
    q_tag.push_back(tag);
  endtask

  // monitor: compares one queued item after each rising edge
  always @(posedge clk) begin
    #1;
    if (q_res.size() > 0) begin
      logic [W-1:0] er;
      logic [3:0]   ef;
      string        tg;
      er = q_res.pop_front();
      ef = q_flg.pop_front();
      tg = q_tag.pop_front();
      check(result == er, {tg, " result"}, result, er);
      check(flags == ef, {tg, " flags"}, {28'd0, flags}, {28'd0, ef});
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; op_a = '0; op_b = '0; opcode = '0; shamt = '0; set_flags = 1'b0;
    exp_flags = 4'b0000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(flags == 4'b0000, "R10 reset value", {28'd0, flags}, 32'd0);

    // R10: flag-setting subtract presented as reset releases
    op_a = 32'd5; op_b = 32'd5; opcode = 4'd1; set_flags = 1'b1; rst_n = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check(flags == 4'b0000, "R10 first two edges ignored", {28'd0, flags}, 32'd0);
    @(posedge clk); @(negedge clk);
    check(flags == 4'b0110, "R10 third edge updates", {28'd0, flags}, 32'h6);
    exp_flags = 4'b0110;

    drive(32'h1234_5678, 32'h1234_5678, 4'd1, 0, 1'b1, "R2 self subtract");
    drive(32'hFFFF_FFFF, 32'h0000_0001, 4'd0, 0, 1'b1, "R1 carry wrap");
    drive(32'h7FFF_FFFF, 32'h0000_0001, 4'd0, 0, 1'b1, "R1 signed overflow");
    drive(32'h0000_001F, 32'h0000_000B, 4'd0, 0, 1'b1, "R1 plain add");
    drive(32'h0000_0004, 32'h0000_0006, 4'd1, 0, 1'b1, "R2 borrow");
    drive(32'h0000_000D, 32'h0000_000C, 4'd1, 0, 1'b1, "R2 no borrow");
    drive(32'h8000_0000, 32'h0000_0001, 4'd1, 0, 1'b1, "R2 overflow sets C and V");
    drive(32'hFFFF_FFFF, 32'h0000_0000, 4'd2, 0, 1'b1, "R5 AND zero keeps CV");
    drive(32'hFEDC_BA98, 32'h0F0F_0F0F, 4'd5, 0, 1'b1, "R3 R5 BIC");
    drive(32'hFEDC_BA98, 32'h0F0F_0F0F, 4'd3, 0, 1'b0, "R3 ORR");
    drive(32'hFEDC_BA98, 32'h0F0F_0F0F, 4'd4, 0, 1'b1, "R3 EOR");
    drive(32'h0, 32'hFEDC_BA98, 4'd6, 0, 1'b1, "R3 R4 MVN");
    drive(32'h0000_0001, 32'h0, 4'd8, 1, 1'b1, "R6 LSR carry out");
    drive(32'h8000_0001, 32'h0, 4'd7, 1, 1'b1, "R6 LSL carry out");
    drive(32'h1000_0000, 32'h0, 4'd7, 4, 1'b1, "R6 LSL zero result");
    drive(32'h0000_00F0, 32'h0, 4'd8, 5, 1'b1, "R6 LSR drop zero");
    drive(32'h8000_0000, 32'h1, 4'd1, 0, 1'b1, "R2 set C and V again");
    drive(32'hA5A5_0000, 32'h0, 4'd7, 0, 1'b1, "R7 LSL by zero");
    drive(32'h0000_0000, 32'h0, 4'd8, 0, 1'b1, "R7 LSR by zero");
    drive(32'h7FFF_FFFF, 32'h1, 4'd0, 0, 1'b0, "R8 add without set-flags");
    drive(32'h5, 32'h5, 4'd1, 0, 1'b0, "R8 zero result without set-flags");
    drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'd12, 3, 1'b1, "R9 reserved 12");
    drive(32'h0, 32'h0, 4'd15, 0, 1'b1, "R9 reserved 15");
    drive(32'h0, 32'h0, 4'd9, 0, 1'b1, "R9 reserved 9");
    drive(32'h0, 32'h0, 4'd2, 0, 1'b0, "R8 idle");
    @(posedge clk); @(posedge clk);

    // R10: asynchronous clear mid-run
    @(negedge clk);
    set_flags = 1'b0;
    check(flags != 4'b0000, "R10 flags nonzero before reset", {28'd0, flags}, 32'h0);
    rst_n = 1'b0;
    #0.5;
    check(flags == 4'b0000, "R10 async clear", {28'd0, flags}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(flags == 4'b0000, "R10 cleared after release", {28'd0, flags}, 32'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule